// File: doc/BRIEF.md
# SONET Section Descrambler and B1 Parity Monitor

This block sits on the receive side of a SONET section terminator. It runs after frame alignment. It takes a byte stream with a valid qualifier, a frame-start marker and the row and column of each byte. It removes the frame-synchronous scrambling from every byte except the framing and trace bytes at the start of row 0, which it passes through unchanged. The output is the same stream, one cycle later.

While the stream passes through, the block folds every received (still scrambled) byte into an even bit-interleaved parity byte. At each frame start it keeps the finished parity of the frame that just ended. When the parity byte of the new frame arrives (row 1, column 0), the block descrambles it and compares it with the kept value. Every bit that differs is added to a saturating error counter. A one-cycle error pulse marks a frame whose parity failed. A read strobe copies the counter to a read port and clears it, and an increment that arrives in the same cycle is carried into the copy.

A small state machine governs whether a comparison is allowed. It has three states:
- `ST_IDLE`: no frame start has been seen since reset.
- `ST_FIRST`: a frame is being accumulated, but no trustworthy parity exists for the frame before it.
- `ST_RUN`: the previous frame was complete, so the comparison is made.

It has three transitions:
- `IDLE->FIRST`: the first frame start.
- `FIRST/RUN->RUN`: a frame start that directly follows row 8, last column.
- `any->FIRST`: a frame start that arrives anywhere else, which is a resynchronisation.

Top module: `sbip_section_rx`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and `out_data` carries the processed byte in that cycle.
- R2: The keystream comes from a 7-bit register. Each key bit is register bit 6. After each bit the register becomes {bits 5..0, bit6 XOR bit5}, which is the generator 1 + x^6 + x^7.
  - Key bits are taken MSB first, eight per byte.
  - The register is forced to all ones for the byte at row 0, column 3·STS_N, and advances only on descrambled bytes.
  - Each such byte is output as input XOR key, so the first key byte of a frame is 0xFE.
- R3: Bytes at row 0, columns 0 to 3·STS_N−1 (the framing and trace bytes) are output unchanged.
- R4: While `cfg_bypass` is 1, every byte is output unchanged. The parity is then compared with the raw parity byte.
- R5: The parity of a frame is the XOR of all its received bytes, from its frame-start byte up to the byte before the next frame start. It is compared with the descrambled byte at row 1, column 0 of the next frame. On a mismatch, `b1_err` is high for exactly the cycle in which that byte leaves on `out_data`, and low at all other times.
- R6: No comparison is made, no error pulse is given and nothing is counted in the frame after the first frame start, or in the frame after a frame start that did not directly follow row 8, column 90·STS_N−1.
- R7: On each comparison the count of differing bits (0 to 8) is added to a CNT_W-bit counter. The counter holds at its all-ones value instead of wrapping.
- R8: When `rd_stb` is high, `rd_data` in the next cycle shows the counter value, saturated, including any increment from the same cycle, and the counter restarts from zero.
- R9: After reset, `out_valid`, `b1_err` and `rd_data` are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | 1 disables descrambling |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | Frame start, asserted with row 0 column 0 |
| in_row | input | 4 | Row of the input byte, 0 to 8 |
| in_col | input | COL_W | Column of the input byte, 0 to 90·STS_N−1 |
| in_data | input | 8 | Received scrambled byte |
| rd_stb | input | 1 | Read-and-clear strobe for the error counter |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Descrambled byte |
| b1_err | output | 1 | Parity mismatch pulse aligned with the parity byte |
| rd_data | output | CNT_W | Counter value captured by the last read strobe |

## Verification
A wrong keystream state corrupts the very next descrambled byte at `out_data`, one cycle after input, and every later byte up to the next keystream restart. A fault in the parity accumulator or in the kept parity stays hidden until row 1 of the following frame. There it shows as a wrong `b1_err` pulse, and as a wrong count at the next read. A fault in the sync state shows as a pulse, or a missing pulse, in the first frame after reset or after a resynchronisation. The error counter can only be seen through a read, so each read is timed against frames with known error masks, including one read that lands in the same cycle as an increment.

// File: rtl/sbip_pkg.sv
package sbip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } sync_st_e;

    localparam int LFSR_W = 7;

    // Eight keystream bits, MSB first, from a given register value.
    function automatic logic [7:0] key_byte(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        logic [7:0]        k;
        t = s;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = t[6];
            t    = {t[5:0], t[6] ^ t[5]};
        end
        return k;
    endfunction

    // Register value after eight steps.
    function automatic logic [LFSR_W-1:0] adv_byte(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[5:0], t[6] ^ t[5]};
        end
        return t;
    endfunction

    function automatic logic [3:0] popcnt8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/sbip_scrambler.sv
module sbip_scrambler
    import sbip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_en,
    input  logic       restart,
    output logic [7:0] key
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] seed;

    always_comb begin
        seed = restart ? {LFSR_W{1'b1}} : st_q;
        key  = key_byte(seed);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {LFSR_W{1'b1}};
        end else if (adv_en) begin
            st_q <= adv_byte(seed);
        end
    end
endmodule

// File: rtl/sbip_bip.sv
module sbip_bip (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sof,
    input  logic [7:0] raw,
    output logic [7:0] prev_bip
);
    logic [7:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            prev_bip <= '0;
        end else if (en) begin
            if (sof) begin
                prev_bip <= acc_q;
                acc_q    <= raw;
            end else begin
                acc_q    <= acc_q ^ raw;
            end
        end
    end
endmodule

// File: rtl/sbip_errcnt.sv
module sbip_errcnt #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rd_data
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;

    always_comb begin
        sum = {1'b0, cnt} + (inc_en ? (CNT_W+1)'(inc) : '0);
        sat = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= sat;
            cnt     <= '0;
        end else begin
            cnt     <= sat;
        end
    end
endmodule

// File: rtl/sbip_section_rx.sv
module sbip_section_rx
    import sbip_pkg::*;
#(
    parameter  int STS_N = 1,
    parameter  int CNT_W = 16,
    localparam int COLS  = 90 * STS_N,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bypass,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [3:0]       in_row,
    input  logic [COL_W-1:0] in_col,
    input  logic [7:0]       in_data,
    input  logic             rd_stb,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             b1_err,
    output logic [CNT_W-1:0] rd_data
);
    localparam int OVH_END  = 3 * STS_N;
    localparam int LAST_ROW = 8;

    sync_st_e         state, state_nx;
    logic             last_end;
    logic             ovh, restart, is_b1, is_end, do_cmp;
    logic [7:0]       key, desc, prev_bip;
    logic [3:0]       nbits;
    logic [CNT_W-1:0] err_cnt;

    always_comb begin
        ovh     = (in_row == 4'd0) && (in_col < COL_W'(OVH_END));
        restart = (in_row == 4'd0) && (in_col == COL_W'(OVH_END));
        is_b1   = in_valid && (in_row == 4'd1) && (in_col == '0);
        is_end  = (in_row == 4'(LAST_ROW)) && (in_col == COL_W'(COLS - 1));
        desc    = (cfg_bypass || ovh) ? in_data : (in_data ^ key);
        do_cmp  = is_b1 && (state == ST_RUN);
        nbits   = popcnt8(desc ^ prev_bip);
    end

    sbip_scrambler u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (in_valid && !ovh),
        .restart (restart),
        .key     (key)
    );

    sbip_bip u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_valid),
        .sof      (in_sof),
        .raw      (in_data),
        .prev_bip (prev_bip)
    );

    sbip_errcnt #(.CNT_W(CNT_W), .INC_W(4)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (do_cmp),
        .inc     (nbits),
        .rd_stb  (rd_stb),
        .cnt     (err_cnt),
        .rd_data (rd_data)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        if (in_valid && in_sof) begin
            unique case (state)
                ST_IDLE:  state_nx = ST_FIRST;
                ST_FIRST: state_nx = last_end ? ST_RUN : ST_FIRST;
                ST_RUN:   state_nx = last_end ? ST_RUN : ST_FIRST;
                default:  state_nx = ST_FIRST;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            last_end <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_valid) begin
                last_end <= is_end;
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            b1_err    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= desc;
            end
            b1_err <= do_cmp && (nbits != 4'd0);
        end
    end
endmodule

// File: rtl/sbip_section_rx_chk.sv
module sbip_section_rx_chk
    import sbip_pkg::*;
#(
    parameter  int STS_N = 1,
    parameter  int CNT_W = 16,
    localparam int COLS  = 90 * STS_N,
    localparam int COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_bypass,
    input logic             in_valid,
    input logic [3:0]       in_row,
    input logic [COL_W-1:0] in_col,
    input logic [7:0]       in_data,
    input logic             rd_stb,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             b1_err,
    input sync_st_e         state,
    input logic [CNT_W-1:0] err_cnt
);
    localparam int OVH_END = 3 * STS_N;

    assert_valid_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_ovh_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_row == 4'd0 && in_col < COL_W'(OVH_END)) |=> (out_data == $past(in_data)));
    assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_bypass) |=> (out_data == $past(in_data)));
    assert_err_only_b1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_row == 4'd1 && in_col == '0) |=> !b1_err);
    assert_no_cmp_unsynced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> !b1_err);
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && err_cnt == {CNT_W{1'b1}}) |=> (err_cnt == {CNT_W{1'b1}}));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (err_cnt == '0));
endmodule

bind sbip_section_rx sbip_section_rx_chk #(.STS_N(STS_N), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bypass (cfg_bypass),
    .in_valid   (in_valid),
    .in_row     (in_row),
    .in_col     (in_col),
    .in_data    (in_data),
    .rd_stb     (rd_stb),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .b1_err     (b1_err),
    .state      (state),
    .err_cnt    (err_cnt)
);

// File: tb/sim_sbip_section_rx.sv
module sim_sbip_section_rx;
    localparam int CLK_PERIOD = 10;
    localparam int STS_N   = 1;
    localparam int COLS    = 90 * STS_N;
    localparam int COL_W   = $clog2(COLS);
    localparam int OVH_END = 3 * STS_N;
    localparam int SMALL_W = 5;
    localparam int MAX0    = 65535;
    localparam int MAX1    = (1 << SMALL_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_bypass = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic [3:0] in_row = '0;
    logic [COL_W-1:0] in_col = '0;
    logic [7:0] in_data = '0;
    logic rd_stb = 1'b0;
    logic out_valid, out_valid1, b1_err, b1_err1;
    logic [7:0] out_data, out_data1;
    logic [15:0] rd_data;
    logic [SMALL_W-1:0] rd_data1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbip_section_rx #(.STS_N(STS_N), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .in_valid(in_valid),
        .in_sof(in_sof), .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .rd_stb(rd_stb), .out_valid(out_valid), .out_data(out_data),
        .b1_err(b1_err), .rd_data(rd_data));

    sbip_section_rx #(.STS_N(STS_N), .CNT_W(SMALL_W)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .in_valid(in_valid),
        .in_sof(in_sof), .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .rd_stb(rd_stb), .out_valid(out_valid1), .out_data(out_data1),
        .b1_err(b1_err1), .rd_data(rd_data1));

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [6:0] m_lf = 7'h7F;
    logic [7:0] m_acc = '0;
    logic [7:0] m_prev = '0;
    bit m_seen = 0, m_last_end = 0, m_run = 0;
    int m_cnt0 = 0, m_cnt1 = 0;
    // Expectations for the next sample
    bit e_valid = 0, e_err = 0, e_rd = 0;
    logic [7:0] e_data = '0;
    string e_dtag = "R2", e_etag = "R5";
    int e_rd0 = 0, e_rd1 = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_key();
        logic [7:0] k;
        for (int i = 7; i >= 0; i--) begin
            k[i] = m_lf[6];
            m_lf = {m_lf[5:0], m_lf[6] ^ m_lf[5]};
        end
        return k;
    endfunction

    // Check the previous cycle, then drive one cycle and predict it.
    task automatic cycle(input bit v, input int r, input int c, input logic [7:0] din,
                         input bit rd, input logic [7:0] mask);
        logic [7:0] key, d, o;
        bit ovh, sof;
        int inc;
        @(negedge clk);
        chk("R1", out_valid, e_valid);
        if (e_valid) chk(e_dtag, out_data, e_data);
        chk(e_etag, b1_err, e_err);
        if (e_rd) begin
            chk("R8", rd_data, e_rd0);
            chk("R7", rd_data1, e_rd1);
        end
        d = din;
        inc = 0;
        e_err = 0;
        sof = v && r == 0 && c == 0;
        if (v) begin
            ovh = (r == 0 && c < OVH_END);
            if (r == 0 && c == OVH_END) m_lf = 7'h7F;
            key = ovh ? 8'h00 : model_key();
            if (r == 1 && c == 0) d = m_prev ^ mask ^ (cfg_bypass ? 8'h00 : key);
            if (sof) begin
                m_run = m_seen && m_last_end;
                m_prev = m_acc;
                m_acc = d;
                m_seen = 1;
            end else begin
                m_acc = m_acc ^ d;
            end
            m_last_end = (r == 8 && c == COLS - 1);
            o = (cfg_bypass || ovh) ? d : d ^ key;
            e_data = o;
            e_dtag = ovh ? "R3" : (cfg_bypass ? "R4" : "R2");
            if (r == 1 && c == 0) begin
                e_etag = m_run ? "R5" : "R6";
                if (m_run) begin
                    inc = $countones(o ^ m_prev);
                    e_err = (inc != 0);
                end
            end else begin
                e_etag = "R5";
            end
        end
        e_valid = v;
        e_rd = rd;
        if (rd) begin
            e_rd0 = (m_cnt0 + inc > MAX0) ? MAX0 : m_cnt0 + inc;
            e_rd1 = (m_cnt1 + inc > MAX1) ? MAX1 : m_cnt1 + inc;
            m_cnt0 = 0;
            m_cnt1 = 0;
        end else begin
            m_cnt0 = (m_cnt0 + inc > MAX0) ? MAX0 : m_cnt0 + inc;
            m_cnt1 = (m_cnt1 + inc > MAX1) ? MAX1 : m_cnt1 + inc;
        end
        in_valid = v;
        in_sof = sof;
        in_row = 4'(r);
        in_col = COL_W'(c);
        in_data = d;
        rd_stb = rd;
    endtask

    task automatic idle(input int n, input bit rd_last);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 8'h00, rd_last && i == n - 1, 8'h00);
    endtask

    task automatic send_frame(input logic [7:0] mask, input int nrows, input bit rd_b1);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < COLS; c++) begin
                cycle(1, r, c, 8'($urandom), rd_b1 && r == 1 && c == 0, mask);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", out_valid, 0);
        chk("R9", b1_err, 0);
        chk("R9", rd_data, 0);
        idle(2, 1);                       // R9: counter reads zero
        idle(1, 0);
        send_frame(8'hFF, 9, 0);          // R6: first frame, no comparison
        send_frame(8'hFF, 9, 0);          // R6: parity of the first frame is trusted now
        send_frame(8'h00, 9, 0);          // R5: clean frame
        send_frame(8'h81, 9, 0);          // R5/R7: two bit errors
        send_frame(8'hFF, 9, 1);          // R8: read in the same cycle as an increment
        idle(1, 0);
        cfg_bypass = 1'b1;                // R4
        send_frame(8'h10, 9, 0);
        send_frame(8'h00, 9, 0);
        idle(1, 0);
        cfg_bypass = 1'b0;
        send_frame(8'h00, 9, 0);
        send_frame(8'h5A, 4, 0);          // truncated frame
        send_frame(8'hFF, 9, 0);          // R6: resync, no comparison
        send_frame(8'h03, 9, 0);
        for (int k = 0; k < 5; k++) send_frame(8'hFF, 9, 0);  // R7: saturate the narrow counter
        idle(3, 1);
        idle(2, 1);                       // R8: cleared after the read
        idle(1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule